// File: doc/BRIEF.md
# Oversampled Resynchronizing Serial Receiver

This block recovers asynchronous serial characters from a single input line. It runs from a system clock. A phase enable `tick_i` pulses at sixteen times the bit rate, and the receiver moves forward only on cycles where that enable is high. A character is a low start bit, eight or nine data bits sent least-significant first, and a high stop bit. Each bit is split into sixteen phases. Three samples are taken in the middle of every bit, and the bit's value is the majority of those three samples.

Inside a frame, a falling edge near a bit boundary resets the phase counter to that edge. This lets the receiver follow a transmitter whose bit period is a little longer or shorter than sixteen phases. When the stop bit has been sampled, the receiver delivers the word with a one-cycle strobe. It also reports whether the stop bit was clean and whether any bit's three samples disagreed.

Top module: `uart_os_rx`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o`, `frame_err_o` and `noise_o` are 0, `data_o` is zero and the receiver is waiting for a falling edge.
- R2: With `nine_bit_i`=0, a frame is one low start bit, eight data bits least-significant first and one high stop bit. The bits appear on `data_o[7:0]` and `data_o[8]` reads 0.
- R3: With `nine_bit_i`=1, nine data bits are received least-significant first into `data_o[8:0]`. The mode is captured when the start edge is detected.
- R4: Phase numbering works as follows.
  - The tick on which the falling start edge is first seen is phase 1 of the start bit, and each bit lasts 16 ticks.
  - A bit is decided on phase 10 as the majority of its samples at phases 8, 9 and 10.
  - The first stop sample is taken 151 ticks (8-bit mode) or 167 ticks (9-bit mode) after phase 1 of the start bit.
  - A stop bit that rises by tick 151 (or 167) is accepted. One that rises a tick later gives a framing error.
- R5: A start bit is accepted only if all three of its samples are low. Otherwise the receiver returns to idle without a strobe, leaves its outputs unchanged, and waits for the next falling edge.
- R6: If the three stop samples are not all high, `frame_err_o` is 1 for that character. The strobe and the data are still delivered.
- R7: If any bit of the character has three samples that do not all agree, `noise_o` is 1 for that character. The bit still takes the majority value.
- R8: A falling edge inside a data bit resets the phase counter so that the edge tick becomes phase 1.
  - The edge must be seen in the first four phases of a bit, where it realigns the current bit, or in the last four phases, where it starts the next bit.
  - With this realignment, alternating-bit characters sent at 15 or 17 ticks per bit are received with no error.
  - An all-zero character at 17 ticks per bit has no edge to realign on, so it gives a framing error with noise.
- R9: State and the phase counter change only on cycles where `tick_i` is high. `rxd_i` passes through a two-flop synchronizer before it is used.
- R10: `valid_o` is high for exactly one clock per received character. `data_o`, `frame_err_o` and `noise_o` hold their values until the next strobe or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Phase enable, 16 per bit period |
| rxd_i | input | 1 | Serial input line, idles high |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| data_o | output | 9 | Received word, right-aligned |
| valid_o | output | 1 | One-cycle strobe for a completed character |
| frame_err_o | output | 1 | Stop bit was not high at all three samples |
| noise_o | output | 1 | Some bit's three samples disagreed |

## Verification
The hardest case to reach is the realignment path. A drifting transmitter has to move edges into the early and late windows of a bit while the mid-bit samples still land inside the right bit. The bench builds each frame tick by tick, with a chosen bit period of 15, 16 or 17 ticks and a fixed one-tick synchronizer offset. This lets it place edges, single-tick glitches and a delayed stop rise on exact phases. Examples are a stop bit that rises exactly at the first stop sample, or one tick after it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_phase.sv
module uart_rx_phase #(
  parameter int OSR   = 16,
  parameter int CNT_W = $clog2(OSR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,  // current tick becomes phase 1
  input  logic             hold_i,  // park at phase 1 while idle
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (tick_i) begin
      if (load_i)        cnt_o <= CNT_W'(1);
      else if (hold_i)   cnt_o <= '0;
      else if (wrap_o)   cnt_o <= '0;
      else               cnt_o <= cnt_o + 1'b1;
    end
  end

  assign wrap_o = tick_i && (cnt_o == LAST);
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic maj_o,
  output logic split_o
);
  assign maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign split_o = (a_i | b_i | c_i) & ~(a_i & b_i & c_i);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              noise_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] PH_S0     = CNT_W'(OSR / 2 - 1);  // RT8
  localparam logic [CNT_W-1:0] PH_S1     = CNT_W'(OSR / 2);      // RT9
  localparam logic [CNT_W-1:0] PH_S2     = CNT_W'(OSR / 2 + 1);  // RT10
  localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(OSR / 4 - 1);
  localparam logic [CNT_W-1:0] LATE_LIM  = CNT_W'(OSR - OSR / 4);
  localparam logic [BIT_W-1:0] LAST_LONG  = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(DATA_W - 2);

  rx_state_e         state_q;
  logic              rx_s, rx_prev_q, fall;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [1:0]        samp_q;
  logic              maj, split, decide;
  logic              resync, late, advance;
  logic [BIT_W-1:0]  bit_idx_q, last_idx;
  logic              mode_q, noise_acc_q;
  logic [DATA_W-1:0] shreg_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  assign fall   = tick_i && rx_prev_q && !rx_s;
  assign late   = (cnt >= LATE_LIM);
  assign resync = (state_q == RX_DATA) && fall && ((cnt <= EARLY_LIM) || late);

  uart_rx_phase #(.OSR(OSR), .CNT_W(CNT_W)) i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .load_i(((state_q == RX_IDLE) && fall) || resync),
    .hold_i(state_q == RX_IDLE),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  uart_rx_vote i_vote (
    .a_i    (samp_q[0]),
    .b_i    (samp_q[1]),
    .c_i    (rx_s),
    .maj_o  (maj),
    .split_o(split)
  );

  assign decide   = tick_i && (state_q != RX_IDLE) && (cnt == PH_S2);
  assign advance  = (wrap && !resync) || (resync && late);
  assign last_idx = mode_q ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_prev_q <= 1'b1;
      samp_q    <= '1;
    end else if (tick_i) begin
      rx_prev_q <= rx_s;
      if (cnt == PH_S0) samp_q[0] <= rx_s;
      if (cnt == PH_S1) samp_q[1] <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      bit_idx_q   <= '0;
      mode_q      <= 1'b0;
      noise_acc_q <= 1'b0;
      shreg_q     <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      noise_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (fall) begin
            state_q     <= RX_START;
            mode_q      <= nine_bit_i;
            noise_acc_q <= 1'b0;
            shreg_q     <= '0;
            bit_idx_q   <= '0;
          end
          RX_START: begin
            if (decide && (maj || split)) state_q <= RX_IDLE;
            else if (wrap)                state_q <= RX_DATA;
          end
          RX_DATA: begin
            if (decide) begin
              shreg_q[bit_idx_q] <= maj;
              noise_acc_q        <= noise_acc_q | split;
            end
            if (advance) begin
              if (bit_idx_q == last_idx) state_q <= RX_STOP;
              else                       bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
          RX_STOP: if (decide) begin
            state_q     <= RX_IDLE;
            valid_o     <= 1'b1;
            data_o      <= shreg_q;
            frame_err_o <= split | ~maj;
            noise_o     <= noise_acc_q | split;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R10
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(frame_err_o) && $stable(noise_o))); // R10
  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(cnt))); // R9
  AST_VALID_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(state_q) == RX_STOP && state_q == RX_IDLE)); // R6
  AST_STOP_AT_RT10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(cnt) == PH_S2 && $past(tick_i))); // R4
endmodule

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       tick_run = 1'b1;
  logic       rxd_i = 1'b1;
  logic       nine_bit_i = 1'b0;
  logic [8:0] data_o;
  logic       valid_o, frame_err_o, noise_o;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int vhigh  = 0;
  logic [8:0] cap_data;
  logic       cap_fe, cap_noise;

  always #2.5 clk = ~clk;

  uart_os_rx i_uart_os_rx (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rxd_i      (rxd_i),
    .nine_bit_i (nine_bit_i),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .frame_err_o(frame_err_o),
    .noise_o    (noise_o)
  );

  // One tick every third clock.
  initial forever begin
    @(negedge clk); tick_i = tick_run;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk);
  end

  always @(negedge clk) if (valid_o) begin
    vcount++;
    cap_data  = data_o;
    cap_fe    = frame_err_o;
    cap_noise = noise_o;
  end

  always @(negedge clk) if (valid_o) vhigh++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one line value for one tick period.
  task automatic put(input logic v);
    do @(posedge clk); while (!tick_i);
    @(negedge clk);
    rxd_i = v;
  endtask

  // stop_at: index where stop rises (-1 = nominal); glitch: index to invert (-1 = none)
  task automatic send(input logic [8:0] d, input logic nine, input int per,
                      input int stop_at, input logic stop_low, input int glitch,
                      input int pause_at);
    int nb, tot, b;
    logic v;
    nb = nine ? 9 : 8;
    nine_bit_i = nine;
    vcount = 0;
    vhigh  = 0;
    tot = (nb + 2) * per;
    if (stop_at >= 0 && stop_at + per > tot) tot = stop_at + per;
    for (int i = 0; i < tot; i++) begin
      b = i / per;
      if (b == 0)       v = 1'b0;
      else if (b <= nb) v = d[b-1];
      else if (stop_at >= 0 && i < stop_at) v = d[nb-1];
      else if (stop_low && b == nb + 1) v = 1'b0;
      else v = 1'b1;
      if (i == glitch) v = ~v;
      if (i == pause_at) begin
        tick_run = 1'b0;
        repeat (90) @(negedge clk);
        tick_run = 1'b1;
      end
      put(v);
    end
    repeat (24) put(1'b1);
  endtask

  task automatic expect_frame(input string req, input logic [8:0] d, input logic fe,
                              input logic nz);
    check({req, " strobe count"}, vcount, 1);
    check({req, " strobe width"}, vhigh, 1);
    check({req, " data"}, cap_data, d);
    check({req, " frame_err"}, cap_fe, fe);
    check({req, " noise"}, cap_noise, nz);
  endtask

  // {data[17:9], nine[8], period[7:2], fe[1], noise[0]}
  localparam logic [17:0] TBL [0:9] = '{
    {9'h0A5, 1'b0, 6'd16, 1'b0, 1'b0},
    {9'h03C, 1'b0, 6'd16, 1'b0, 1'b0},
    {9'h1A5, 1'b1, 6'd16, 1'b0, 1'b0},
    {9'h0FF, 1'b0, 6'd16, 1'b0, 1'b0},
    {9'h055, 1'b0, 6'd17, 1'b0, 1'b0},
    {9'h0AA, 1'b0, 6'd17, 1'b0, 1'b0},
    {9'h055, 1'b0, 6'd15, 1'b0, 1'b0},
    {9'h0AA, 1'b0, 6'd15, 1'b0, 1'b0},
    {9'h155, 1'b1, 6'd17, 1'b0, 1'b0},
    {9'h000, 1'b0, 6'd17, 1'b1, 1'b1}
  };

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs under and after reset
    check("R1 valid in reset", valid_o, 0);
    check("R1 data in reset", data_o, 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 data after reset", data_o, 0);
    check("R1 flags after reset", {frame_err_o, noise_o}, 0);
    repeat (10) put(1'b1);

    // R2 R3 R8: vector table, nominal and drifting bit periods
    for (int k = 0; k < 10; k++) begin
      logic [8:0] d;
      logic nine;
      d    = TBL[k][17:9];
      nine = TBL[k][8];
      send(d, nine, int'(TBL[k][7:2]), -1, 1'b0, -1, -1);
      expect_frame($sformatf("R2/R3/R8 vec%0d", k), nine ? d : {1'b0, d[7:0]},
                   TBL[k][1], TBL[k][0]);
    end

    // R5: short low pulse rejected, outputs unchanged
    vcount = 0;
    repeat (5) put(1'b0);
    repeat (30) put(1'b1);
    check("R5 short pulse no strobe", vcount, 0);
    check("R5 data unchanged", data_o, 9'h000);
    // R5: RT9 sample high during start rejected
    vcount = 0;
    for (int i = 0; i < 16; i++) put(i == 8);
    repeat (30) put(1'b1);
    check("R5 split start no strobe", vcount, 0);
    send(9'h05A, 1'b0, 16, -1, 1'b0, -1, -1);
    expect_frame("R5 recovery", 9'h05A, 0, 0);

    // R7: glitch at RT9 of data bit 3
    send(9'h0FF, 1'b0, 16, -1, 1'b0, 72, -1);
    expect_frame("R7 data glitch", 9'h0FF, 0, 1);
    // R6 R7: glitch at RT9 of stop
    send(9'h0C3, 1'b0, 16, -1, 1'b0, 152, -1);
    expect_frame("R6 stop glitch", 9'h0C3, 1, 1);
    // R6: stop held low
    send(9'h03C, 1'b0, 16, -1, 1'b1, -1, -1);
    expect_frame("R6 stop low", 9'h03C, 1, 0);

    // R4: stop rise boundary, 8-bit and 9-bit
    send(9'h000, 1'b0, 16, 151, 1'b0, -1, -1);
    expect_frame("R4 stop at 151", 9'h000, 0, 0);
    send(9'h000, 1'b0, 16, 152, 1'b0, -1, -1);
    expect_frame("R4 stop at 152", 9'h000, 1, 1);
    send(9'h000, 1'b1, 16, 167, 1'b0, -1, -1);
    expect_frame("R4 9-bit stop at 167", 9'h000, 0, 0);
    send(9'h000, 1'b1, 16, 168, 1'b0, -1, -1);
    expect_frame("R4 9-bit stop at 168", 9'h000, 1, 1);

    // R9: ticks paused mid-frame
    send(9'h0B6, 1'b0, 16, -1, 1'b0, -1, 70);
    expect_frame("R9 tick pause", 9'h0B6, 0, 0);

    // R10: outputs held after strobe
    repeat (40) @(negedge clk);
    check("R10 data held", data_o, 9'h0B6);
    check("R10 valid low", valid_o, 0);

    // R1: reset mid-frame
    nine_bit_i = 1'b0;
    repeat (40) put(1'b0);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R1 data cleared", data_o, 0);
    rxd_i = 1'b1;
    @(negedge clk); rst_ni = 1'b1;
    repeat (10) put(1'b1);
    send(9'h081, 1'b0, 16, -1, 1'b0, -1, -1);
    expect_frame("R1 after mid reset", 9'h081, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule